// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns interrupt events into fixed 128-bit vectors and writes them one after another into a circular buffer held in local memory, which the host can read through a separate read port. An event arrives on a valid/ready port. Its fields are the source code, a 28-bit payload, a ring tag, a VM identifier and an address-space identifier. Each accepted event fills the slot under the write pointer, and the pointer then moves on by one vector.

The host sees the ring through a small register file. It sets the ring size as a base-2 logarithm of 32-bit words. It consumes vectors by moving the read pointer forward. It learns of new work from an interrupt line that stays high while the two pointers differ. When the ring would fill up completely, the block sets a sticky overflow flag in bit 0 of the readable write-pointer word and goes on writing. A separate control bit clears the flag. Writeback can be switched on, and then every write-pointer update is also sent out on a writeback port together with a 4-byte-aligned address.

Top module: `ivr_writer`

## Requirements
- R1: After synchronous reset, `ev_ready`, `irq` and `wb_valid` are low and every register reads as zero.
- R2: An accepted event is stored at vector index wptr/16 as a 128-bit word. Source goes in bits [7:0], payload in [59:32], ring tag in [71:64], VM identifier in [79:72] and address-space identifier in [95:80]. All other bits are zero. `mem_rdata` returns the word at `mem_raddr` one cycle after the address is applied.
- R3: Pointers count bytes. Each accepted event adds 16 to the write pointer, modulo the ring size in bytes, 4*2^L. L is CTRL[5:1], and values below 3 act as 3 while values above log2(4*DEPTH_VEC) act as that maximum. The write pointer changes only when an event is accepted or the ring is disabled.
- R4: `ev_ready` is high only while CTRL[0] (ring enable) and CTRL[9] (interrupt enable) are both set. At most one event is accepted per clock.
- R5: `irq` is high exactly when the read and write pointers differ or the overflow flag is set, and it is aligned with the pointer state.
- R6: A write to RPTR (register 2) loads the read pointer with the written value, masked to the ring size and rounded down to a multiple of 16.
- R7: If CTRL[6] (overflow enable) is set and an accepted event moves the write pointer onto the current read pointer, the overflow flag is set. The vector is still written and the pointer still advances. The flag appears as bit 0 of WPTR (register 3, read-only, byte pointer in the upper bits).
- R8: The overflow flag stays set until CTRL is written with bit 7 set. Bit 7 always reads back as 0. A new overflow in the same cycle wins over the clear. With CTRL[6] clear, no overflow is ever flagged.
- R9: Writing CTRL with bit 0 clear returns both pointers and the overflow flag to zero in that same cycle and lowers `irq`. While the ring is disabled, RPTR writes have no effect.
- R10: With CTRL[8] (writeback enable) set, each accepted event gives a one-cycle `wb_valid` pulse in the cycle the write pointer updates. `wb_data` then equals the new WPTR word and `wb_addr` equals the WBADDR register. With CTRL[8] clear, no pulse appears.
- R11: BASE (register 1, ring address shifted right by 8) reads back as written. WBADDR (register 4) reads back with bits [1:0] forced to zero. `reg_rdata` shows the register selected by `reg_addr` one cycle later (0 CTRL, 1 BASE, 2 RPTR, 3 WPTR, 4 WBADDR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_src | input | 8 | Event source code |
| ev_data | input | 28 | Event payload |
| ev_tag | input | 8 | Ring tag (engine/pipe/queue) |
| ev_vmid | input | 8 | VM identifier |
| ev_space | input | 16 | Address-space identifier |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle latency |
| mem_raddr | input | 6 | Host read index into the ring (vectors) |
| mem_rdata | output | 128 | Vector at `mem_raddr`, one cycle latency |
| irq | output | 1 | Ring has unread vectors or overflow |
| wb_valid | output | 1 | Writeback pulse |
| wb_addr | output | 32 | Writeback address, 4-byte aligned |
| wb_data | output | 32 | Writeback value (WPTR word) |

## Verification
Several properties are checked on every cycle: pointer alignment to 16 bytes, the write pointer holding still when no event is accepted, `ev_ready` dropping after a control write that clears either enable, the zeroed state right after a disable, the stickiness of the overflow flag, `irq` being high whenever the pointers differ, and writeback pulses appearing only after an accept and only at an aligned address. Other behaviour can only be shown by the bench's scenarios against its queue model. That covers the exact vector layout in memory, wrap-around at each clamped ring size, where the overflow fires and how it clears, and the masking of host read-pointer writes.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int REG_W   = 32;
  localparam int RADDR_W = 3;
  localparam int VEC_W   = 128;
  localparam int SRC_W   = 8;
  localparam int INFO_W  = 28;
  localparam int TAG_W   = 8;
  localparam int VMID_W  = 8;
  localparam int SPACE_W = 16;
  localparam int LOG2_W  = 5;

  // control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_LOG2    = 1;
  localparam int CB_OVF_EN  = 6;
  localparam int CB_OVF_CLR = 7;
  localparam int CB_WB_EN   = 8;
  localparam int CB_INT_EN  = 9;

  typedef enum logic [RADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_BASE   = 3'd1,
    RA_RPTR   = 3'd2,
    RA_WPTR   = 3'd3,
    RA_WBADDR = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              int_en;
    logic              wb_en;
    logic              ovf_en;
    logic [LOG2_W-1:0] log2_dw;
    logic              ring_en;
  } ctrl_t;

  // field layout decoded by the host: keep positions fixed
  function automatic logic [VEC_W-1:0] pack_vector(
    input logic [SRC_W-1:0]   src,
    input logic [INFO_W-1:0]  info,
    input logic [TAG_W-1:0]   tag,
    input logic [VMID_W-1:0]  vmid,
    input logic [SPACE_W-1:0] space
  );
    logic [VEC_W-1:0] v;
    v        = '0;
    v[7:0]   = src;
    v[59:32] = info;
    v[71:64] = tag;
    v[79:72] = vmid;
    v[95:80] = space;
    return v;
  endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [PTR_W-1:0]   wptr,
  input  logic [PTR_W-1:0]   rptr,
  input  logic               ovf,
  output ctrl_t              ctrl,
  output logic               ring_en_nxt,
  output logic               ovf_clr,
  output logic               rptr_wr,
  output logic [REG_W-1:0]   wb_addr_reg,
  output logic [REG_W-1:0]   reg_rdata
);
  localparam int ZEXT = REG_W - PTR_W;

  logic             ctrl_wr;
  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] wptr_word;
  logic [REG_W-1:0] rptr_word;

  always_comb begin
    ctrl_wr     = reg_we && (reg_addr == RA_CTRL);
    ring_en_nxt = ctrl_wr ? reg_wdata[CB_EN] : ctrl.ring_en;
    ovf_clr     = ctrl_wr && reg_wdata[CB_OVF_CLR];
    rptr_wr     = reg_we && (reg_addr == RA_RPTR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl        <= '0;
      base_q      <= '0;
      wb_addr_reg <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: ctrl <= '{int_en:  reg_wdata[CB_INT_EN],
                           wb_en:   reg_wdata[CB_WB_EN],
                           ovf_en:  reg_wdata[CB_OVF_EN],
                           log2_dw: reg_wdata[CB_LOG2 +: LOG2_W],
                           ring_en: reg_wdata[CB_EN]};
        RA_BASE:   base_q      <= reg_wdata;
        RA_WBADDR: wb_addr_reg <= {reg_wdata[REG_W-1:2], 2'b00};
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_word                     = '0;
    ctrl_word[CB_EN]              = ctrl.ring_en;
    ctrl_word[CB_LOG2 +: LOG2_W]  = ctrl.log2_dw;
    ctrl_word[CB_OVF_EN]          = ctrl.ovf_en;
    ctrl_word[CB_WB_EN]           = ctrl.wb_en;
    ctrl_word[CB_INT_EN]          = ctrl.int_en;
    wptr_word = {{ZEXT{1'b0}}, wptr | {{(PTR_W-1){1'b0}}, ovf}};
    rptr_word = {{ZEXT{1'b0}}, rptr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:   reg_rdata <= ctrl_word;
        RA_BASE:   reg_rdata <= base_q;
        RA_RPTR:   reg_rdata <= rptr_word;
        RA_WPTR:   reg_rdata <= wptr_word;
        RA_WBADDR: reg_rdata <= wb_addr_reg;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivr_ptrs.sv
module ivr_ptrs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int MAX_L = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en_nxt,
  input  logic [LOG2_W-1:0] log2_dw,
  input  logic              ovf_en,
  input  logic              ovf_clr,
  input  logic              rptr_wr,
  input  logic [PTR_W-1:0]  rptr_wdata,
  input  logic              accept,
  input  logic              wb_en,
  output logic [PTR_W-1:0]  wptr_q,
  output logic [PTR_W-1:0]  rptr_q,
  output logic              ovf_q,
  output logic              irq_q,
  output logic              wb_valid_q,
  output logic [REG_W-1:0]  wb_word_q
);
  localparam int ZEXT = REG_W - PTR_W;
  localparam logic [LOG2_W-1:0] L_MIN = LOG2_W'(3);
  localparam logic [LOG2_W-1:0] L_MAX = LOG2_W'(MAX_L);
  localparam logic [PTR_W:0]    SPAN_UNIT = (PTR_W+1)'(4);
  localparam logic [PTR_W:0]    SPAN_ONE  = (PTR_W+1)'(1);
  localparam logic [PTR_W-1:0]  VEC_BYTES = PTR_W'(16);
  localparam logic [PTR_W-1:0]  ALIGN     = ~PTR_W'(15);

  logic [LOG2_W-1:0] eff_l;
  logic [PTR_W:0]    span;
  logic [PTR_W-1:0]  ring_mask;
  logic [PTR_W-1:0]  step_ptr;
  logic [PTR_W-1:0]  wptr_nxt;
  logic [PTR_W-1:0]  rptr_nxt;
  logic              hit;
  logic              ovf_nxt;

  always_comb begin
    if (log2_dw < L_MIN)      eff_l = L_MIN;
    else if (log2_dw > L_MAX) eff_l = L_MAX;
    else                      eff_l = log2_dw;
    span      = SPAN_UNIT << eff_l;
    ring_mask = PTR_W'(span - SPAN_ONE);
    step_ptr  = (wptr_q + VEC_BYTES) & ring_mask;
    rptr_nxt  = rptr_wr ? (rptr_wdata & ring_mask & ALIGN) : rptr_q;
    wptr_nxt  = accept ? step_ptr : wptr_q;
    // filling the last free slot makes full look like empty
    hit       = accept && ovf_en && (step_ptr == rptr_q);
    ovf_nxt   = (ovf_q && !ovf_clr) || hit;
    if (!ring_en_nxt) begin
      wptr_nxt = '0;
      rptr_nxt = '0;
      ovf_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      ovf_q      <= 1'b0;
      irq_q      <= 1'b0;
      wb_valid_q <= 1'b0;
      wb_word_q  <= '0;
    end else begin
      wptr_q     <= wptr_nxt;
      rptr_q     <= rptr_nxt;
      ovf_q      <= ovf_nxt;
      irq_q      <= (wptr_nxt != rptr_nxt) || ovf_nxt;
      wb_valid_q <= accept && wb_en && ring_en_nxt;
      if (accept)
        wb_word_q <= {{ZEXT{1'b0}}, wptr_nxt | {{(PTR_W-1){1'b0}}, ovf_nxt}};
    end
  end
endmodule

// File: rtl/ivr_store.sv
module ivr_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 128,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int DEPTH_VEC = 64,
  parameter int IDX_W     = $clog2(DEPTH_VEC),
  parameter int PTR_W     = IDX_W + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [SRC_W-1:0]     ev_src,
  input  logic [INFO_W-1:0]    ev_data,
  input  logic [TAG_W-1:0]     ev_tag,
  input  logic [VMID_W-1:0]    ev_vmid,
  input  logic [SPACE_W-1:0]   ev_space,
  input  logic                 reg_we,
  input  logic [RADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [IDX_W-1:0]     mem_raddr,
  output logic [VEC_W-1:0]     mem_rdata,
  output logic                 irq,
  output logic                 wb_valid,
  output logic [REG_W-1:0]     wb_addr,
  output logic [REG_W-1:0]     wb_data
);
  localparam int MAX_L = IDX_W + 2;

  ctrl_t            ctrl;
  logic             ring_en;
  logic             ring_en_nxt;
  logic             ovf_clr;
  logic             rptr_wr;
  logic             accept;
  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] rptr_q;
  logic             ovf_q;
  logic [VEC_W-1:0] vec;

  assign ring_en  = ctrl.ring_en;
  assign ev_ready = ctrl.ring_en && ctrl.int_en;
  assign accept   = ev_valid && ev_ready;
  assign vec      = pack_vector(ev_src, ev_data, ev_tag, ev_vmid, ev_space);

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .wptr       (wptr_q),
    .rptr       (rptr_q),
    .ovf        (ovf_q),
    .ctrl       (ctrl),
    .ring_en_nxt(ring_en_nxt),
    .ovf_clr    (ovf_clr),
    .rptr_wr    (rptr_wr),
    .wb_addr_reg(wb_addr),
    .reg_rdata  (reg_rdata)
  );

  ivr_ptrs #(.PTR_W(PTR_W), .MAX_L(MAX_L)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .ring_en_nxt(ring_en_nxt),
    .log2_dw    (ctrl.log2_dw),
    .ovf_en     (ctrl.ovf_en),
    .ovf_clr    (ovf_clr),
    .rptr_wr    (rptr_wr),
    .rptr_wdata (reg_wdata[PTR_W-1:0]),
    .accept     (accept),
    .wb_en      (ctrl.wb_en),
    .wptr_q     (wptr_q),
    .rptr_q     (rptr_q),
    .ovf_q      (ovf_q),
    .irq_q      (irq),
    .wb_valid_q (wb_valid),
    .wb_word_q  (wb_data)
  );

  ivr_store #(.DEPTH(DEPTH_VEC), .WIDTH(VEC_W), .IDX_W(IDX_W)) u_store (
    .clk  (clk),
    .we   (accept),
    .waddr(wptr_q[PTR_W-1:4]),
    .wdata(vec),
    .raddr(mem_raddr),
    .rdata(mem_rdata)
  );
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq,
  input logic             wb_valid,
  input logic [31:0]      wb_addr,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] rptr,
  input logic             ovf,
  input logic             ring_en
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == 3'd0);

  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    (wptr[3:0] == 4'd0) && (rptr[3:0] == 4'd0));

  p_wptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_ready) && !ctrl_wr |=> $stable(wptr));

  p_ready_off_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !(reg_wdata[0] && reg_wdata[9]) |=> !ev_ready);

  p_irq_pending_r5: assert property (@(posedge clk) disable iff (rst)
    ring_en && (wptr != rptr) |-> irq);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf && !(ctrl_wr && (reg_wdata[7] || !reg_wdata[0])) |=> ovf);

  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !reg_wdata[0] |=> (wptr == '0) && (rptr == '0) && !ovf && !irq);

  p_wb_cause_r10: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_ready) |=> !wb_valid);

  p_wb_align_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_addr[1:0] == 2'b00));
endmodule

bind ivr_writer ivr_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_valid (ev_valid),
  .ev_ready (ev_ready),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq      (irq),
  .wb_valid (wb_valid),
  .wb_addr  (wb_addr),
  .wptr     (wptr_q),
  .rptr     (rptr_q),
  .ovf      (ovf_q),
  .ring_en  (ring_en)
);

// File: tb/ivr_writer_tb.sv
module ivr_writer_tb;
  localparam int DEPTH = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ev_valid = 1'b0;
  logic         ev_ready;
  logic [7:0]   ev_src = '0;
  logic [27:0]  ev_data = '0;
  logic [7:0]   ev_tag = '0;
  logic [7:0]   ev_vmid = '0;
  logic [15:0]  ev_space = '0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [5:0]   mem_raddr = '0;
  logic [127:0] mem_rdata;
  logic         irq;
  logic         wb_valid;
  logic [31:0]  wb_addr;
  logic [31:0]  wb_data;

  ivr_writer u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_tag(ev_tag), .ev_vmid(ev_vmid),
    .ev_space(ev_space), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .irq(irq), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  always #5 clk = ~clk;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit finished = 1'b0;

  // model state
  logic [127:0] m_mem [DEPTH];
  int unsigned m_w = 0, m_r = 0, m_mask = 63, m_last = 0;
  bit m_ovf = 0, m_en = 0, m_oe = 0, m_wb = 0;
  logic [31:0] m_wbaddr = '0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int unsigned mask_of(int unsigned l);
    int unsigned e;
    e = (l < 3) ? 3 : ((l > 8) ? 8 : l);
    return (4 << e) - 1;
  endfunction

  function automatic logic [127:0] exp_vec(logic [7:0] s, logic [27:0] d,
      logic [7:0] t, logic [7:0] v, logic [15:0] p);
    logic [127:0] x;
    x = '0;
    x[7:0] = s; x[59:32] = d; x[71:64] = t; x[79:72] = v; x[95:80] = p;
    return x;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_ctrl(input bit en, input int unsigned l, input bit oe,
                          input bit clr, input bit wb, input bit ie);
    logic [31:0] w;
    w = 32'(en) | (32'(l & 31) << 1) | (32'(oe) << 6) | (32'(clr) << 7)
        | (32'(wb) << 8) | (32'(ie) << 9);
    reg_write(3'd0, w);
    m_en = en; m_oe = oe; m_wb = wb; m_mask = mask_of(l);
    if (clr) m_ovf = 0;
    if (!en) begin m_w = 0; m_r = 0; m_ovf = 0; end
  endtask

  task automatic set_rptr(input int unsigned v);
    reg_write(3'd2, 32'(v));
    if (m_en) m_r = v & m_mask & ~32'd15;
  endtask

  task automatic check_ptrs(input string req);
    logic [31:0] d;
    reg_read(3'd3, d);
    chk(req, "WPTR word", 128'(d), 128'(m_w | m_ovf));
    reg_read(3'd2, d);
    chk(req, "RPTR word", 128'(d), 128'(m_r));
  endtask

  task automatic check_irq(input string req);
    chk(req, "irq", 128'(irq), 128'((m_w != m_r) || m_ovf));
  endtask

  task automatic check_mem(input int unsigned idx);
    mem_raddr = 6'(idx);
    @(posedge clk); @(negedge clk);
    chk("R2", "stored vector", mem_rdata, m_mem[idx]);
  endtask

  task automatic push();
    logic [127:0] v;
    int unsigned nxt;
    ev_src = 8'($urandom); ev_data = 28'($urandom); ev_tag = 8'($urandom);
    ev_vmid = 8'($urandom); ev_space = 16'($urandom);
    v = exp_vec(ev_src, ev_data, ev_tag, ev_vmid, ev_space);
    ev_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    ev_valid = 1'b0;
    nxt = (m_w + 16) & m_mask;
    if (m_oe && nxt == m_r) m_ovf = 1;
    m_mem[m_w / 16] = v;
    m_last = m_w / 16;
    m_w = nxt;
    if (m_wb) begin
      chk("R10", "wb_valid", 128'(wb_valid), 128'(1));
      chk("R10", "wb_data", 128'(wb_data), 128'(m_w | m_ovf));
      chk("R10", "wb_addr", 128'(wb_addr), 128'(m_wbaddr));
    end else begin
      chk("R10", "wb_valid off", 128'(wb_valid), 128'(0));
    end
    check_irq("R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "ev_ready", 128'(ev_ready), 128'(0));
    chk("R1", "irq", 128'(irq), 128'(0));
    chk("R1", "wb_valid", 128'(wb_valid), 128'(0));
    reg_read(3'd0, d); chk("R1", "CTRL", 128'(d), 128'(0));
    reg_read(3'd3, d); chk("R1", "WPTR", 128'(d), 128'(0));

    // R11 base and writeback address registers
    reg_write(3'd1, 32'h0012_3456);
    reg_read(3'd1, d); chk("R11", "BASE", 128'(d), 128'h0012_3456);
    reg_write(3'd4, 32'h0000_1003); m_wbaddr = 32'h0000_1000;
    reg_read(3'd4, d); chk("R11", "WBADDR aligned", 128'(d), 128'(m_wbaddr));

    // enable: 16 dwords = 4 vectors
    set_ctrl(1, 4, 1, 0, 1, 1);
    chk("R4", "ready on", 128'(ev_ready), 128'(1));
    reg_read(3'd0, d);
    chk("R11", "CTRL readback", 128'(d), 128'(32'h349));
    push(); push();
    check_ptrs("R3");
    check_mem(0); check_mem(1);

    // R6 read pointer writes
    set_rptr(32); check_irq("R5");
    chk("R5", "irq idle", 128'(irq), 128'(0));
    set_rptr(32'h3F7);
    check_ptrs("R6");
    check_irq("R6");
    set_rptr(32);

    // wrap and overflow (R3, R7)
    push(); push(); push();
    check_ptrs("R3");
    check_mem(3); check_mem(0);
    push();
    check_ptrs("R7");
    chk("R7", "irq on overflow", 128'(irq), 128'(1));
    push();
    check_ptrs("R8");
    set_ctrl(1, 4, 1, 1, 1, 1);
    check_ptrs("R8");
    reg_read(3'd0, d);
    chk("R8", "clear bit reads zero", 128'(d[7]), 128'(0));

    // overflow detection off, writeback off
    set_ctrl(1, 4, 0, 0, 0, 1);
    push(); push(); push();
    check_ptrs("R8");
    check_irq("R5");

    // R4 ready gate
    set_ctrl(1, 4, 0, 0, 1, 0);
    chk("R4", "ready off", 128'(ev_ready), 128'(0));
    ev_valid = 1'b1;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R4", "no wb while blocked", 128'(wb_valid), 128'(0));
    end
    ev_valid = 1'b0;
    check_ptrs("R4");

    // R9 disable
    set_ctrl(0, 4, 0, 0, 0, 0);
    chk("R9", "irq after disable", 128'(irq), 128'(0));
    check_ptrs("R9");
    set_rptr(48);
    check_ptrs("R9");

    // R3 clamp low: L=0 behaves as 3 (two vectors)
    set_ctrl(1, 0, 0, 0, 0, 1);
    push(); push(); push();
    check_ptrs("R3");
    set_ctrl(0, 0, 0, 0, 0, 0);

    // R3 clamp high: L=31 behaves as 8 (64 vectors)
    set_ctrl(1, 31, 0, 0, 0, 1);
    for (int i = 0; i < 63; i++) push();
    check_ptrs("R3");
    push();
    check_ptrs("R3");
    set_ctrl(0, 0, 0, 0, 0, 0);

    // random phase, 8 vectors
    set_ctrl(1, 5, 1, 0, 1, 1);
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom % 8;
      case (op)
        0, 1, 2, 3: push();
        4: set_rptr(m_w);
        5: if (m_r != m_w) set_rptr((m_r + 16) & m_mask);
        6: if (m_ovf) set_ctrl(1, 5, 1, 1, 1, 1);
        default: begin
          @(posedge clk); @(negedge clk);
          chk("R10", "idle no wb", 128'(wb_valid), 128'(0));
        end
      endcase
      check_irq("R5");
      if (it % 25 == 24) begin
        check_ptrs("R7");
        check_mem(m_last);
      end
    end
    check_ptrs("R3");

    summary();
  end
endmodule